// File: doc/BRIEF.md
# Carry-Deferred 32-bit Adder Slice

This block adds two 32-bit operands without being given a carry-in. It presents both candidate results at once: the sum that applies if the incoming carry is 0 and the sum that applies if it is 1. It also presents the slice's group generate and group propagate. An enclosing end-around-carry adder feeds the group terms into its own carry logic. That logic works out the carry into the slice, and the carry picks one of the two sums outside this block.

Inside, the operands are cut into four byte lanes. Each lane is a conditional-sum sub-block with its own bit-level parallel prefix network. Each lane yields two lane sums, two lane carry-outs and a lane generate/propagate pair. A second prefix network runs at byte granularity, so its sparseness is 8. It turns the four lane pairs into the carry entering each lane, once for slice carry-in 0 and once for slice carry-in 1. It also gives the full-width group terms. The carry entering a lane then selects between that lane's two sums and between its two carry-outs. The block is purely combinational.

Top module: `eac_add_slice`

## Requirements
- R1: `sum_c0_o` equals (a_i + b_i) mod 2^32.
- R2: `sum_c1_o` equals (a_i + b_i + 1) mod 2^32, so it is always `sum_c0_o` + 1 modulo 2^32.
- R3: `grp_g_o` is 1 exactly when a_i + b_i carries out of bit 31.
- R4: `grp_p_o` is 1 exactly when a_i XOR b_i has all 32 bits set. Whenever it is 1, `sum_c0_o` is all ones and `sum_c1_o` is zero.
- R5: `grp_g_o` and `grp_p_o` are never 1 at the same time.
- R6: The carry out of a_i + b_i + 1 equals `grp_g_o` OR `grp_p_o`. The carry-select chain for carry-in 1 gives the same value from the top lane.
- R7: Every output follows its operands in the same cycle, with no clock or stored state. A carry produced in lane 0 reaches lane 3 through the sparse network. An example is 0x00FFFFFF + 0x00000001, which gives 0x01000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| sum_c0_o | output | 32 | Sum assuming slice carry-in 0 |
| sum_c1_o | output | 32 | Sum assuming slice carry-in 1 |
| grp_g_o | output | 1 | Slice group generate |
| grp_p_o | output | 1 | Slice group propagate |

## Verification
On every evaluation, the checker ties the two sums together and matches the carry-0 sum and group generate against a 33-bit reference addition. It checks that generate and propagate exclude each other, and that a full propagate forces the all-ones and zero sums. It also compares the carry-outs that emerge from the top lane's selection chain with the group terms. Two things only the bench's scenarios can show: that lane carries ripple correctly across byte boundaries in chosen patterns, and that the outputs stay right under thousands of random operand pairs and the all-zero, all-one and wrap-around corners.

// File: rtl/eac_add_slice_pkg.sv
package eac_add_slice_pkg;
  parameter int unsigned SLICE_W_DEF = 32;
  parameter int unsigned LANE_W_DEF  = 8;

  function automatic int unsigned lane_count(input int unsigned slice_w, input int unsigned lane_w);
    return slice_w / lane_w;
  endfunction
endpackage

// File: rtl/ks_prefix.sv
// Kogge-Stone prefix: gpre_o[k] / ppre_o[k] are group terms over [k:0]
module ks_prefix #(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0] g_i,
  input  logic [N-1:0] p_i,
  output logic [N-1:0] gpre_o,
  output logic [N-1:0] ppre_o
);
  localparam int unsigned LVLS = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0] g_lv [LVLS+1];
  logic [N-1:0] p_lv [LVLS+1];

  assign g_lv[0] = g_i;
  assign p_lv[0] = p_i;

  for (genvar l = 0; l < LVLS; l++) begin : g_lvl
    localparam int unsigned DIST = 1 << l;
    for (genvar k = 0; k < N; k++) begin : g_node
      if (k >= DIST) begin : g_merge
        assign g_lv[l+1][k] = g_lv[l][k] | (p_lv[l][k] & g_lv[l][k-DIST]);
        assign p_lv[l+1][k] = p_lv[l][k] & p_lv[l][k-DIST];
      end else begin : g_pass
        assign g_lv[l+1][k] = g_lv[l][k];
        assign p_lv[l+1][k] = p_lv[l][k];
      end
    end
  end

  assign gpre_o = g_lv[LVLS];
  assign ppre_o = p_lv[LVLS];
endmodule

// File: rtl/csel_lane.sv
// Conditional-sum lane: both sums and both carry-outs, plus lane G/P
module csel_lane #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum0_o,
  output logic [W-1:0] sum1_o,
  output logic         cout0_o,
  output logic         cout1_o,
  output logic         g_o,
  output logic         p_o
);
  logic [W-1:0] bit_g, bit_p, pre_g, pre_p;
  logic [W-1:0] cy0, cy1;

  assign bit_g = a_i & b_i;
  assign bit_p = a_i ^ b_i;

  ks_prefix #(.N(W)) u_pfx (
    .g_i    (bit_g),
    .p_i    (bit_p),
    .gpre_o (pre_g),
    .ppre_o (pre_p)
  );

  assign cy0 = {pre_g[W-2:0], 1'b0};
  assign cy1 = {pre_g[W-2:0] | pre_p[W-2:0], 1'b1};

  assign sum0_o  = bit_p ^ cy0;
  assign sum1_o  = bit_p ^ cy1;
  assign g_o     = pre_g[W-1];
  assign p_o     = pre_p[W-1];
  assign cout0_o = pre_g[W-1];
  assign cout1_o = pre_g[W-1] | pre_p[W-1];
endmodule

// File: rtl/eac_add_slice.sv
module eac_add_slice #(
  parameter int unsigned WIDTH   = eac_add_slice_pkg::SLICE_W_DEF,
  parameter int unsigned GROUP_W = eac_add_slice_pkg::LANE_W_DEF
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] sum_c0_o,
  output logic [WIDTH-1:0] sum_c1_o,
  output logic             grp_g_o,
  output logic             grp_p_o
);
  localparam int unsigned NLANE = eac_add_slice_pkg::lane_count(WIDTH, GROUP_W);

  logic [NLANE-1:0] lane_g, lane_p, lane_co0, lane_co1;
  logic [NLANE-1:0] hi_g, hi_p;
  logic [NLANE-1:0] lane_ci0, lane_ci1;
  logic [NLANE-1:0] sel_co0, sel_co1;
  logic [WIDTH-1:0] lsum0, lsum1;

  for (genvar k = 0; k < NLANE; k++) begin : g_lane
    csel_lane #(.W(GROUP_W)) u_lane (
      .a_i     (a_i[k*GROUP_W +: GROUP_W]),
      .b_i     (b_i[k*GROUP_W +: GROUP_W]),
      .sum0_o  (lsum0[k*GROUP_W +: GROUP_W]),
      .sum1_o  (lsum1[k*GROUP_W +: GROUP_W]),
      .cout0_o (lane_co0[k]),
      .cout1_o (lane_co1[k]),
      .g_o     (lane_g[k]),
      .p_o     (lane_p[k])
    );
  end

  // sparse level: one prefix node per lane
  ks_prefix #(.N(NLANE)) u_sparse (
    .g_i    (lane_g),
    .p_i    (lane_p),
    .gpre_o (hi_g),
    .ppre_o (hi_p)
  );

  for (genvar k = 0; k < NLANE; k++) begin : g_sel
    if (k == 0) begin : g_first
      assign lane_ci0[k] = 1'b0;
      assign lane_ci1[k] = 1'b1;
    end else begin : g_rest
      assign lane_ci0[k] = hi_g[k-1];
      assign lane_ci1[k] = hi_g[k-1] | hi_p[k-1];
    end
    assign sum_c0_o[k*GROUP_W +: GROUP_W] = lane_ci0[k] ? lsum1[k*GROUP_W +: GROUP_W]
                                                        : lsum0[k*GROUP_W +: GROUP_W];
    assign sum_c1_o[k*GROUP_W +: GROUP_W] = lane_ci1[k] ? lsum1[k*GROUP_W +: GROUP_W]
                                                        : lsum0[k*GROUP_W +: GROUP_W];
    assign sel_co0[k] = lane_ci0[k] ? lane_co1[k] : lane_co0[k];
    assign sel_co1[k] = lane_ci1[k] ? lane_co1[k] : lane_co0[k];
  end

  assign grp_g_o = hi_g[NLANE-1];
  assign grp_p_o = hi_p[NLANE-1];
endmodule

// File: rtl/eac_add_slice_chk.sv
module eac_add_slice_chk #(
  parameter int unsigned WIDTH   = 32,
  parameter int unsigned GROUP_W = 8
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [WIDTH-1:0] sum_c0_o,
  input logic [WIDTH-1:0] sum_c1_o,
  input logic             grp_g_o,
  input logic             grp_p_o,
  input logic             top_co0,
  input logic             top_co1
);
  logic [WIDTH:0] ref_sum;
  assign ref_sum = {1'b0, a_i} + {1'b0, b_i};

  always_comb begin
    p_sum0_gen_r1: assert ({grp_g_o, sum_c0_o} == ref_sum);
    p_sum1_step_r2: assert (sum_c1_o == sum_c0_o + 1'b1);
    p_gen_chain_r3: assert (top_co0 == grp_g_o);
    p_prop_xor_r4: assert (grp_p_o == (&(a_i ^ b_i)));
    p_prop_sums_r4: assert (!grp_p_o || (sum_c0_o == '1 && sum_c1_o == '0));
    p_gp_excl_r5: assert (!(grp_g_o && grp_p_o));
    p_c1_chain_r6: assert (top_co1 == (grp_g_o | grp_p_o));
  end
endmodule

bind eac_add_slice eac_add_slice_chk #(.WIDTH(WIDTH), .GROUP_W(GROUP_W)) u_chk (
  .a_i      (a_i),
  .b_i      (b_i),
  .sum_c0_o (sum_c0_o),
  .sum_c1_o (sum_c1_o),
  .grp_g_o  (grp_g_o),
  .grp_p_o  (grp_p_o),
  .top_co0  (sel_co0[NLANE-1]),
  .top_co1  (sel_co1[NLANE-1])
);

// File: tb/tb_eac_add_slice.sv
module tb_eac_add_slice;
  localparam int unsigned W          = 32;
  localparam time         CLK_PERIOD = 10ns;
  localparam int unsigned N_RAND     = 3000;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] a, b, s0, s1;
  logic         g, p;
  int           n_chk = 0;
  int           n_fail = 0;
  bit           done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eac_add_slice dut (
    .a_i      (a),
    .b_i      (b),
    .sum_c0_o (s0),
    .sum_c1_o (s1),
    .grp_g_o  (g),
    .grp_p_o  (p)
  );

  function automatic logic [W:0] ref_add(input logic [W-1:0] x, input logic [W-1:0] y, input logic ci);
    return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
  endfunction

  task automatic chk(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s a=%h b=%h got=%h exp=%h", req, a, b, got, exp);
    end
  endtask

  task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y);
    logic [W:0] r0, r1;
    @(negedge clk);
    a = x;
    b = y;
    #1;
    r0 = ref_add(x, y, 1'b0);
    r1 = ref_add(x, y, 1'b1);
    chk("R1 sum_c0", s0, r0[W-1:0]);
    chk("R2 sum_c1", s1, r1[W-1:0]);
    chk("R3 grp_g", {{(W-1){1'b0}}, g}, {{(W-1){1'b0}}, r0[W]});
    chk("R4 grp_p", {{(W-1){1'b0}}, p}, {{(W-1){1'b0}}, &(x ^ y)});
    chk("R5 g/p exclusive", {{(W-1){1'b0}}, g & p}, '0);
    chk("R6 carry with cin1", {{(W-1){1'b0}}, g | p}, {{(W-1){1'b0}}, r1[W]});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0A11));
    a = '0;
    b = '0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    // R7: zero operands settle with no clocking state
    #1;
    chk("R7 idle sum_c0", s0, '0);
    chk("R7 idle sum_c1", s1, 32'h1);
    apply('0, '0);
    apply('1, '1);
    apply('1, '0);                     // R4: full propagate
    apply(32'h5555_5555, 32'hAAAA_AAAA); // R4
    apply(32'h0000_0001, '1);          // R3 wraps to zero
    apply(32'h8000_0000, 32'h8000_0000);
    apply(32'h00FF_FFFF, 32'h0000_0001); // R7 lane 0 to lane 3
    chk("R7 cross-lane", s0, 32'h0100_0000);
    apply(32'h00FF_00FF, 32'h0001_0001);
    apply(32'hFF00_FF00, 32'h00FF_00FF);
    apply(32'h7FFF_FFFF, 32'h0000_0000);
    for (int i = 0; i < 4; i++) begin
      apply(32'hFF << (8 * i), 32'h1 << (8 * i));
    end
    for (int i = 0; i < N_RAND; i++) begin
      logic [W-1:0] x, y;
      x = $urandom();
      y = $urandom();
      if (i % 5 == 0) y = ~x;
      apply(x, y);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule